// File: doc/BRIEF.md
# Serial Peripheral Master Controller

A single-channel SPI master for a simple synchronous register bus. Software sees two 16-bit words. The control/status word (address 0) holds the rate, the polarity, the phase, the transfer length, the enable, the interrupt enable and the completion flag. The data word (address 1) holds the outgoing bits before an exchange and the incoming bits after it. Software loads the data word and writes the control word with the enable set. It then writes the control word again with both the enable bit and the exchange bit set. The block produces the serial clock and launches and samples one bit per clock pulse. When the exchange ends it raises the completion flag, which drives the interrupt line if the interrupt is enabled.

Rate, polarity, phase and length are captured when an exchange starts and stay fixed for that exchange. A write to the control word during an exchange changes only the stored values that software reads back. Clearing the enable during an exchange abandons it.

Top module: `spim_master`

## Requirements
- R1: Rate code `rate` in control bits [15:13] gives a serial clock half-period of 2^(rate+1) system clock cycles, so the division ranges from 4 up to 512. The exchange bit reads 1 for exactly 2·N·2^(rate+1) cycles, counted from the clock edge that accepts the start write, where N is the number of bits.
- R2: While no exchange runs, the serial clock rests at the level of the polarity bit (control bit 4). After every completed or abandoned exchange it returns to that level.
- R3: With the phase bit (control bit 5) at 0, the transmit line changes only on the edge that leaves the rest level, and each receive bit is sampled on the edge that returns to it. With polarity 0 this means launch on rising edges and sample on falling edges; polarity 1 swaps the two edges.
- R4: With phase 1, the first transmit bit is presented when the exchange starts. Receive bits are sampled on the edge that leaves the rest level, and the next bit is launched on the edge that returns to it.
- R5: A bit-count field value L in control bits [3:0] gives exactly L+1 clock pulses. Transmission starts at data bit L and moves toward bit 0, and received bits enter at bit 0. Afterwards data bits [L:0] hold the received bits in arrival order, with the first received bit at position L, and the bits above L read 0.
- R6: An exchange starts only on a control write that has bit 9 (enable) and bit 8 (exchange) both set while no exchange runs. Bit 8 reads 1 while an exchange runs. A write with bit 8 set and bit 9 clear starts nothing.
- R7: Bit 7 (completion flag) is set when an exchange completes. A control write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged.
- R8: The interrupt output equals the completion flag ANDed with the interrupt enable bit (control bit 6).
- R9: During an exchange, data-word writes are ignored and control writes with the exchange bit set neither restart nor lengthen the running exchange.
- R10: A control write that clears the enable during an exchange stops it at once. The serial clock goes back to rest and the completion flag is not set.
- R11: After reset both words read 0 and the serial clock, transmit and interrupt outputs are 0. Control bits [12:10] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 1 | Word select: 0 control/status, 1 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the word that bus_addr selects (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial transmit data |
| miso | input | 1 | Serial receive data |
| irq | output | 1 | Interrupt request |

## Verification
An edge counter that is off by one shows in two ways within one exchange: the pulse count on sclk is wrong, and the time until the exchange bit falls is wrong. A swap between launch and sample edges shows at the first sample edge, because mosi then carries the wrong bit or the received word comes back shifted. A fault in the divider stretches every half-period, so the timing check catches it on the first exchange at that rate. A corrupted flag or abort path shows in bit 7 or on irq as soon as the exchange ends or is abandoned.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int RATE_W = 3;
  localparam int HALF_W = (1 << RATE_W) + 1;
  localparam int EDGE_W = LEN_W + 1;

  // Control word bit positions (software decodes these)
  localparam int C_RATE_LSB = 13;
  localparam int C_EN       = 9;
  localparam int C_GO       = 8;
  localparam int C_DONE     = 7;
  localparam int C_IRQEN    = 6;
  localparam int C_PHA      = 5;
  localparam int C_POL      = 4;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              pha;
    logic              pol;
    logic [LEN_W-1:0]  len;
  } xfer_cfg_t;

  // System cycles per serial clock half-period
  function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] rate);
    half_period = HALF_W'(2) << rate;
  endfunction

  // Ones in bits [len:0]
  function automatic logic [DATA_W-1:0] window_mask(input logic [LEN_W-1:0] len);
    window_mask = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(len));
  endfunction

  // Index of the final clock edge: 2*len+1
  function automatic logic [EDGE_W-1:0] last_edge(input logic [LEN_W-1:0] len);
    last_edge = {len, 1'b1};
  endfunction
endpackage

// File: rtl/spim_divider.sv
module spim_divider
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] limit;

  assign limit = half_period(rate) - 1'b1;
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R1: half-period is at least two cycles, so ticks never come back to back
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R1: counter never runs past the selected limit while running
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  xfer_cfg_t         cfg_new,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              miso,
  output logic              busy,
  output xfer_cfg_t         cfg_act,
  output logic              sclk_run,
  output logic              mosi,
  output logic [DATA_W-1:0] shreg,
  output logic              done_ev
);
  logic              busy_q;
  xfer_cfg_t         act_q;
  logic [EDGE_W-1:0] edge_q;
  logic              sclk_q;
  logic              mosi_q;
  logic [DATA_W-1:0] sh_q;

  logic              step;
  logic              lead_edge;
  logic              is_last;
  logic              sample_ev;
  logic              launch_ev;
  logic [DATA_W-1:0] sh_next;

  assign step      = busy_q && tick && !abort;
  assign lead_edge = ~edge_q[0];
  assign is_last   = (edge_q == last_edge(act_q.len));
  assign sample_ev = step && (lead_edge == act_q.pha);
  assign launch_ev = step && (lead_edge != act_q.pha);
  assign done_ev   = step && is_last;
  assign sh_next   = sample_ev ? {sh_q[DATA_W-2:0], miso} : sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      sh_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      act_q  <= cfg_new;
      edge_q <= '0;
      sclk_q <= cfg_new.pol;
      mosi_q <= sh_q[cfg_new.len];
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (step) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      if (is_last) begin
        busy_q <= 1'b0;
        sh_q   <= sh_next & window_mask(act_q.len);
      end else begin
        sh_q <= sh_next;
        if (launch_ev) mosi_q <= sh_q[act_q.len];
      end
    end else if (data_wr && !busy_q) begin
      sh_q <= wdata;
    end
  end

  assign busy     = busy_q;
  assign cfg_act  = act_q;
  assign sclk_run = sclk_q;
  assign mosi     = mosi_q;
  assign shreg    = sh_q;

  // R3: serial clock moves only on a divider tick
  a_r3_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !step) |=> $stable(sclk_q));
  // R4: transmit line changes only on a launch edge during an exchange
  a_r4_mosi_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !launch_ev) |=> $stable(mosi_q));
  // R5: edge index never passes the final edge of the active length
  a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_q <= last_edge(act_q.len)));
  // R2: clock is back at rest once the exchange completes
  a_r2_rest_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (!busy_q && sclk_q == act_q.pol));
  // R9: data word is frozen against bus writes while busy
  a_r9_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && data_wr && !tick) |=> $stable(sh_q));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done_ev,
  input  logic [DATA_W-1:0] data_word,
  output logic [DATA_W-1:0] rdata,
  output logic              start,
  output logic              abort,
  output logic              data_wr,
  output xfer_cfg_t         cfg_new,
  output logic              pol_live,
  output logic              irq
);
  logic [RATE_W-1:0] rate_q;
  logic              en_q;
  logic              done_q;
  logic              irqen_q;
  logic              pha_q;
  logic              pol_q;
  logic [LEN_W-1:0]  len_q;
  logic              ctl_wr;
  logic [DATA_W-1:0] ctrl_rd;

  assign ctl_wr  = wr && (addr == ADDR_CTRL);
  assign data_wr = wr && (addr == ADDR_DATA);
  assign start   = ctl_wr && wdata[C_EN] && wdata[C_GO] && !busy;
  assign abort   = ctl_wr && !wdata[C_EN] && busy;

  assign cfg_new.rate = wdata[C_RATE_LSB +: RATE_W];
  assign cfg_new.pha  = wdata[C_PHA];
  assign cfg_new.pol  = wdata[C_POL];
  assign cfg_new.len  = wdata[0 +: LEN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= '0;
      en_q    <= 1'b0;
      irqen_q <= 1'b0;
      pha_q   <= 1'b0;
      pol_q   <= 1'b0;
      len_q   <= '0;
    end else if (ctl_wr) begin
      rate_q  <= wdata[C_RATE_LSB +: RATE_W];
      en_q    <= wdata[C_EN];
      irqen_q <= wdata[C_IRQEN];
      pha_q   <= wdata[C_PHA];
      pol_q   <= wdata[C_POL];
      len_q   <= wdata[0 +: LEN_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          done_q <= 1'b0;
    else if (done_ev)                    done_q <= 1'b1;
    else if (ctl_wr && !wdata[C_DONE])   done_q <= 1'b0;
  end

  always_comb begin
    ctrl_rd                           = '0;
    ctrl_rd[C_RATE_LSB +: RATE_W]     = rate_q;
    ctrl_rd[C_EN]                     = en_q;
    ctrl_rd[C_GO]                     = busy;
    ctrl_rd[C_DONE]                   = done_q;
    ctrl_rd[C_IRQEN]                  = irqen_q;
    ctrl_rd[C_PHA]                    = pha_q;
    ctrl_rd[C_POL]                    = pol_q;
    ctrl_rd[0 +: LEN_W]               = len_q;
  end

  assign rdata    = (addr == ADDR_DATA) ? data_word : ctrl_rd;
  assign pol_live = pol_q;
  assign irq      = done_q & irqen_q;

  // R6: an exchange never runs with the enable cleared
  a_r6_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_q);
  // R7: completion always lands in the flag
  a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> done_q);
  // R10: an abandoned exchange does not raise the flag
  a_r10_abort_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !done_q) |=> !done_q);
  // R8: completion with the interrupt enabled raises the request
  a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && irqen_q && !ctl_wr) |=> irq);
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  logic              start;
  logic              abort;
  logic              data_wr;
  logic              busy;
  logic              tick;
  logic              done_ev;
  logic              pol_live;
  logic              sclk_run;
  xfer_cfg_t         cfg_new;
  xfer_cfg_t         cfg_act;
  logic [DATA_W-1:0] shreg;

  spim_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .busy      (busy),
    .done_ev   (done_ev),
    .data_word (shreg),
    .rdata     (bus_rdata),
    .start     (start),
    .abort     (abort),
    .data_wr   (data_wr),
    .cfg_new   (cfg_new),
    .pol_live  (pol_live),
    .irq       (irq)
  );

  spim_divider div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .rate  (cfg_act.rate),
    .tick  (tick)
  );

  spim_engine eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .abort    (abort),
    .tick     (tick),
    .cfg_new  (cfg_new),
    .data_wr  (data_wr),
    .wdata    (bus_wdata),
    .miso     (miso),
    .busy     (busy),
    .cfg_act  (cfg_act),
    .sclk_run (sclk_run),
    .mosi     (mosi),
    .shreg    (shreg),
    .done_ev  (done_ev)
  );

  assign sclk = busy ? sclk_run : pol_live;
endmodule

// File: tb/spim_master_tb.sv
`timescale 1ns/1ps
module spim_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        miso = 1'b0;
  wire  [15:0] bus_rdata;
  wire         sclk, mosi, irq;
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  spim_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_half(input int rate);
    int h = 2;
    for (int i = 0; i < rate; i++) h = h * 2;
    return h;
  endfunction

  function automatic logic [15:0] exp_mask(input int len);
    logic [15:0] m = '0;
    for (int i = 0; i <= len; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] ctrl_word(input int rate, input bit en, input bit go,
      input bit done, input bit ie, input bit pha, input bit pol, input int len);
    logic [15:0] w = '0;
    w[15:13] = rate[2:0];
    w[9] = en; w[8] = go; w[7] = done; w[6] = ie; w[5] = pha; w[4] = pol;
    w[3:0] = len[3:0];
    return w;
  endfunction

  task automatic bus_write(input bit a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic bus_read(input bit a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic exchange(input int rate, input bit pol, input bit pha, input int len,
      input bit ie, input logic [15:0] tx, input logic [15:0] slave, input bit disturb);
    logic [15:0] r;
    int cyc = 0, pulses = 0, scnt = 0, lcnt = 0, bad = 0;
    int nbits = len + 1;
    int total = 2 * nbits * exp_half(rate);
    int dist_at = nbits * exp_half(rate);
    bit psclk, pmosi;
    string ph_tag;
    ph_tag = pha ? "R4 launch/sample order" : "R3 launch/sample order";
    bus_write(1'b1, tx);
    bus_write(1'b0, ctrl_word(rate, 1, 0, 0, ie, pha, pol, len));
    check(sclk == pol, "R2 rest level before start", sclk, pol);
    miso = slave[len];
    psclk = sclk; pmosi = mosi;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = ctrl_word(rate, 1, 1, 0, ie, pha, pol, len);
    @(negedge clk);
    bus_wr = 1'b0;
    while (cyc < 20000) begin
      bit dist_cycle;
      dist_cycle = bus_wr;
      bus_wr = 1'b0;
      if (sclk != psclk) begin
        automatic bit is_launch = ((sclk == 1'b1) == (pol == pha));
        if (sclk != pol) pulses++;
        if (is_launch) begin
          automatic int idx = pha ? (len - lcnt - 1) : (len - lcnt);
          if (idx >= 0) miso = slave[idx];
          lcnt++;
        end else begin
          if (scnt <= len && mosi != tx[len - scnt]) bad++;
          scnt++;
          if (mosi != pmosi) bad++;
        end
      end else if (mosi != pmosi && cyc != 0) begin
        bad++;
      end
      psclk = sclk; pmosi = mosi;
      bus_read(1'b0, r);
      if (!dist_cycle && !r[8]) break;
      cyc++;
      if (disturb && cyc == dist_at) begin
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = $urandom();
      end else if (disturb && cyc == dist_at + 2) begin
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = ctrl_word(rate, 1, 1, 0, ie, pha, pol, len);
      end
      @(negedge clk);
    end
    check(cyc == total, disturb ? "R9/R1 busy duration" : "R1 busy duration", cyc, total);
    check(pulses == nbits, "R5 pulse count", pulses, nbits);
    check(bad == 0, ph_tag, bad, 0);
    check(sclk == pol, "R2 rest level after exchange", sclk, pol);
    bus_read(1'b1, r);
    check(r == (slave & exp_mask(len)), disturb ? "R9 received word" : "R5 received word",
          r, slave & exp_mask(len));
    bus_read(1'b0, r);
    check(r[7] == 1'b1, "R7 flag after completion", r[7], 1);
    check(irq == ie, "R8 irq after completion", irq, ie);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R11: reset state
    bus_read(1'b0, r); check(r == 16'h0, "R11 control after reset", r, 0);
    bus_read(1'b1, r); check(r == 16'h0, "R11 data after reset", r, 0);
    check({sclk, mosi, irq} == 3'b000, "R11 outputs after reset", {sclk, mosi, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed mode corners
    exchange(0, 0, 0, 7, 1, 16'h00A5, 16'h003C, 0);
    exchange(0, 1, 0, 7, 0, 16'h0096, 16'h00C3, 0);
    exchange(1, 0, 1, 7, 1, 16'h005A, 16'h0081, 0);
    exchange(1, 1, 1, 4, 0, 16'h0013, 16'h0016, 0);
    exchange(0, 0, 0, 15, 0, 16'hBEEF, 16'h1234, 0);
    exchange(7, 1, 0, 0, 1, 16'h0001, 16'hFFFF, 0);
    exchange(7, 0, 1, 15, 0, 16'h8001, 16'hA55A, 0);
    exchange(2, 0, 1, 9, 1, 16'h02F0, 16'h0155, 1);

    // R7 / R8: flag write semantics and interrupt gating
    bus_write(1'b0, ctrl_word(0, 1, 0, 1, 0, 0, 0, 7));
    bus_read(1'b0, r);
    check(r[7] == 1'b1, "R7 writing 1 keeps flag", r[7], 1);
    check(irq == 1'b0, "R8 irq masked with enable 0", irq, 0);
    bus_write(1'b0, ctrl_word(0, 1, 0, 1, 1, 0, 0, 7));
    check(irq == 1'b1, "R8 irq with flag and enable", irq, 1);
    bus_write(1'b0, ctrl_word(0, 1, 0, 0, 1, 0, 0, 7));
    bus_read(1'b0, r);
    check(r[7] == 1'b0, "R7 writing 0 clears flag", r[7], 0);
    check(irq == 1'b0, "R8 irq drops with flag", irq, 0);

    // R6: exchange bit without enable does nothing
    bus_write(1'b0, ctrl_word(1, 0, 1, 0, 1, 0, 0, 3));
    bus_read(1'b0, r);
    check(r[8] == 1'b0, "R6 no start without enable", r[8], 0);
    repeat (40) @(negedge clk);
    bus_read(1'b0, r);
    check(r[7] == 1'b0 && sclk == 1'b0, "R6 no activity without enable", {r[7], sclk}, 0);

    // R10: abandon mid-exchange
    bus_write(1'b1, 16'hFFFF);
    bus_write(1'b0, ctrl_word(2, 1, 0, 0, 1, 0, 1, 15));
    bus_write(1'b0, ctrl_word(2, 1, 1, 0, 1, 0, 1, 15));
    repeat (30) @(negedge clk);
    bus_write(1'b0, ctrl_word(2, 0, 0, 0, 1, 0, 1, 15));
    bus_read(1'b0, r);
    check(r[8] == 1'b0, "R10 exchange bit after abandon", r[8], 0);
    check(sclk == 1'b1, "R10 clock at rest after abandon", sclk, 1);
    repeat (200) @(negedge clk);
    bus_read(1'b0, r);
    check(r[7] == 1'b0 && irq == 1'b0, "R10 no flag after abandon", {r[7], irq}, 0);

    // R11: reserved bits read zero
    bus_write(1'b0, 16'hFC7F);
    bus_read(1'b0, r);
    check(r == 16'hE07F, "R11 reserved bits read zero", r, 16'hE07F);

    // Random exchanges
    for (int k = 0; k < 24; k++) begin
      automatic int rt = $urandom_range(0, 3);
      automatic int ln = $urandom_range(0, 15);
      automatic bit pl = 1'($urandom_range(0, 1));
      automatic bit ph = 1'($urandom_range(0, 1));
      automatic bit ie = 1'($urandom_range(0, 1));
      automatic bit ds = (ln >= 3) && ($urandom_range(0, 2) == 0);
      exchange(rt, pl, ph, ln, ie, 16'($urandom()), 16'($urandom()), ds);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule